// File: doc/BRIEF.md
# Buffered Compare Interval Timer

This block is a 16-bit up-counting interval timer. It raises a compare-match interrupt at a fixed period and toggles an output line on each match. The count source is selectable. It can be the system clock divided by a power of two from 1 to 128, or the rising edges of an external event line.

While the timer is stopped, the counter rests at all ones. When counting is enabled, the compare value is captured into an internal buffer. The first count event then rolls the counter over to zero and inverts the output. From then on, each count event advances the counter. When the counter equals the buffered value, it clears to zero, the output inverts again and the interrupt pulses for one system clock. The distance between matches is therefore (compare + 1) count events.

Only interval operation (mode field 000) counts. Any other mode value keeps the timer stopped.

Top module: `intv_timer`

## Requirements
- R1: After reset, `tmrOut` and `irq` are 0.
- R2: While the timer is stopped, the counter holds 16'hFFFF. The first count event after enable changes it to 0, so the first match comes on count event N+2, where N is the captured compare value.
- R3: On the count event that starts a run, `tmrOut` inverts (from 0 to 1).
- R4: On a count event where the counter equals the buffered compare value, three things happen on the same clock edge: the counter clears to 0, `tmrOut` inverts and `irq` is raised.
- R5: After the first match, matches repeat every N+1 count events.
- R6: When `extSrc`=0, count events come from a prescaler that divides the system clock by 2^`clkSel` (000 gives 1, 111 gives 128). The prescaler restarts on enable, so the first count event falls on the 2^`clkSel`-th clock edge at which the timer is active.
- R7: `cmpVal` is captured on the first clock edge at which the timer is active. Changes to `cmpVal` during a run have no effect on the match period.
- R8: When `runEn` drops, `tmrOut` and `irq` are 0 from the next clock edge on, and no further matches occur. A later enable starts a fresh run from 16'hFFFF.
- R9: The timer is active only when `runEn`=1 and `modeSel`=3'b000. With any other mode value, it behaves as if stopped.
- R10: When `extSrc`=1, a count event is a rising edge of `evtIn`, seen through a two-flop synchroniser. The prescaler is then ignored.
- R11: `irq` is a single system-clock pulse for each match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| runEn | input | 1 | Counting enable |
| clkSel | input | 3 | Prescaler select, divide by 2^clkSel |
| modeSel | input | 3 | Operating mode, 000 = interval |
| extSrc | input | 1 | 1 = count external events, 0 = prescaled clock |
| cmpVal | input | 16 | Compare value, captured at enable |
| evtIn | input | 1 | External event input (asynchronous) |
| tmrOut | output | 1 | Toggle output |
| irq | output | 1 | Compare-match interrupt pulse |

## Verification
The hardest behaviour to reach is the buffer isolation. A change to `cmpVal` must not alter a run that is already in progress, and the only evidence of this at the ports is the spacing of `irq` pulses. The stimulus enables the timer with one compare value and replaces it two cycles later. It then measures both the first-match latency and the following interval against the captured value. The external-event path is driven with slow, widely spaced pulses while the prescaler is set to divide by one. Any output activity before the first pulse would therefore show that the prescaler leaked through.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  localparam int CNT_W = 16;
  localparam int SEL_W = 3;
  localparam int MODE_W = 3;
  localparam logic [MODE_W-1:0] MODE_INTERVAL = '0;

  typedef struct packed {
    logic hold;     // timer inactive: park counter, clear outputs
    logic loadBuf;  // capture compare value
    logic start;    // first count event of a run
    logic wrap;     // count event with match
    logic step;     // count event without match
  } ivtStrobe_t;
endpackage

// File: rtl/ivt_tickgen.sv
module ivt_tickgen #(
  parameter int SEL_W = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             active,
  input  logic             extSrc,
  input  logic [SEL_W-1:0] clkSel,
  input  logic             evtIn,
  output logic             countEvt
);
  localparam int PRE_W = (1 << SEL_W) - 1;

  logic [PRE_W-1:0] preCnt;
  logic [PRE_W-1:0] preMask;
  logic             preTick;

  assign preMask = ~({PRE_W{1'b1}} << clkSel);
  assign preTick = ((preCnt & preMask) == preMask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) preCnt <= '0;
    else if (!active) preCnt <= '0;
    else preCnt <= preCnt + 1'b1;
  end

  logic [SYNC_STAGES:0] syncChain;
  genvar gi;
  generate
    for (gi = 0; gi <= SYNC_STAGES; gi++) begin : g_sync
      if (gi == 0) begin : g_first
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else syncChain[gi] <= evtIn;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) syncChain[gi] <= 1'b0;
          else syncChain[gi] <= syncChain[gi-1];
        end
      end
    end
  endgenerate

  logic evtRise;
  assign evtRise = syncChain[SYNC_STAGES-1] & ~syncChain[SYNC_STAGES];

  assign countEvt = active & (extSrc ? evtRise : preTick);
endmodule

// File: rtl/ivt_ctrl.sv
module ivt_ctrl
  import ivt_pkg::*;
#(
  parameter int MODE_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [MODE_W-1:0] modeSel,
  input  logic              countEvt,
  input  logic              hit,
  output logic              active,
  output ivtStrobe_t        strobe
);
  logic armed;
  logic started;

  assign active = runEn && (modeSel == MODE_INTERVAL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      started <= 1'b0;
    end else begin
      armed <= active;
      if (!active) started <= 1'b0;
      else if (countEvt) started <= 1'b1;
    end
  end

  always_comb begin
    strobe         = '0;
    strobe.hold    = !active;
    strobe.loadBuf = active && !armed;
    strobe.start   = active && countEvt && !started;
    strobe.wrap    = active && countEvt && started && hit;
    strobe.step    = active && countEvt && started && !hit;
  end
endmodule

// File: rtl/ivt_datapath.sv
module ivt_datapath
  import ivt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ivtStrobe_t       strobe,
  input  logic [CNT_W-1:0] cmpVal,
  output logic             hit,
  output logic             tmrOut,
  output logic             irq
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] bufVal;

  assign hit = (cnt == bufVal);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '1;
    else if (strobe.hold) cnt <= '1;
    else if (strobe.start || strobe.wrap) cnt <= '0;
    else if (strobe.step) cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bufVal <= '0;
    else if (strobe.loadBuf) bufVal <= cmpVal;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      tmrOut <= 1'b0;
      irq    <= 1'b0;
    end else if (strobe.hold) begin
      tmrOut <= 1'b0;
      irq    <= 1'b0;
    end else begin
      if (strobe.start || strobe.wrap) tmrOut <= ~tmrOut;
      irq <= strobe.wrap;
    end
  end
endmodule

// File: rtl/intv_timer.sv
module intv_timer
  import ivt_pkg::*;
#(
  parameter int CW = CNT_W,
  parameter int SW = SEL_W,
  parameter int MW = MODE_W,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          runEn,
  input  logic [SW-1:0] clkSel,
  input  logic [MW-1:0] modeSel,
  input  logic          extSrc,
  input  logic [CW-1:0] cmpVal,
  input  logic          evtIn,
  output logic          tmrOut,
  output logic          irq
);
  ivtStrobe_t strobe;
  logic active;
  logic countEvt;
  logic hit;

  ivt_ctrl #(.MODE_W(MW)) u_ctrl (
    .clk(clk), .rstN(rstN), .runEn(runEn), .modeSel(modeSel),
    .countEvt(countEvt), .hit(hit), .active(active), .strobe(strobe)
  );

  ivt_tickgen #(.SEL_W(SW), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rstN(rstN), .active(active), .extSrc(extSrc),
    .clkSel(clkSel), .evtIn(evtIn), .countEvt(countEvt)
  );

  ivt_datapath #(.CNT_W(CW)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .cmpVal(cmpVal),
    .hit(hit), .tmrOut(tmrOut), .irq(irq)
  );
endmodule

// File: rtl/intv_timer_chk.sv
module intv_timer_chk #(
  parameter int CW = 16,
  parameter int MW = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          runEn,
  input logic [MW-1:0] modeSel,
  input logic          tmrOut,
  input logic          irq,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] bufVal,
  input logic          armed,
  input logic          started
);
  a_r1_reset_quiet: assert property (@(posedge clk) !rstN |=> (!tmrOut && !irq));

  a_r2_parked_all_ones: assert property (@(posedge clk) disable iff (!rstN)
    !started |-> (cnt == {CW{1'b1}}));

  a_r4_irq_with_clear: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> (cnt == '0));

  a_r4_irq_with_toggle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> (tmrOut != $past(tmrOut)));

  a_r7_buffer_held: assert property (@(posedge clk) disable iff (!rstN)
    (armed && $past(armed)) |-> $stable(bufVal));

  a_r8_stopped_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> (!tmrOut && !irq));

  a_r9_mode_gate: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel != '0) |=> (!tmrOut && !irq && !started));
endmodule

bind intv_timer intv_timer_chk #(.CW(CW), .MW(MW)) u_chk (
  .clk(clk), .rstN(rstN), .runEn(runEn), .modeSel(modeSel),
  .tmrOut(tmrOut), .irq(irq), .cnt(u_dp.cnt), .bufVal(u_dp.bufVal),
  .armed(u_ctrl.armed), .started(u_ctrl.started)
);

// File: tb/sim_intv_timer.sv
module sim_intv_timer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic runEn = 1'b0;
  logic [2:0] clkSel = '0;
  logic [2:0] modeSel = '0;
  logic extSrc = 1'b0;
  logic [15:0] cmpVal = '0;
  logic evtIn = 1'b0;
  logic tmrOut;
  logic irq;

  int nChecks = 0;
  int nFails = 0;
  int cycleCnt = 0;

  always #10 clk = ~clk;

  intv_timer u0 (
    .clk(clk), .rstN(rstN), .runEn(runEn), .clkSel(clkSel), .modeSel(modeSel),
    .extSrc(extSrc), .cmpVal(cmpVal), .evtIn(evtIn), .tmrOut(tmrOut), .irq(irq)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycleCnt++;
    if (cycleCnt > 150000) begin
      nFails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cycleCnt);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  task automatic stopTimer();
    @(negedge clk);
    runEn = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  // counts negedges until sig matches val; returns count
  task automatic waitFor(input bit useIrq, input bit val, input int limit, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (((useIrq ? irq : tmrOut) != val) && n < limit);
  endtask

  // R2 R3 R4 R5 R6 R11: full-run timing for one prescaler setting
  task automatic runInternal(input int sel, input int cmp, input string tag);
    int n;
    int scale = 1 << sel;
    @(negedge clk);
    extSrc = 1'b0; clkSel = 3'(sel); cmpVal = 16'(cmp); modeSel = '0; runEn = 1'b1;
    waitFor(0, 1, 5000, n);
    check({tag, " R3/R6 first toggle cycle"}, n, scale);
    waitFor(1, 1, 50000, n);
    check({tag, " R2/R4 first match cycle"}, n + scale, (cmp + 2) * scale);
    check({tag, " R4 output toggled back on match"}, tmrOut, 0);
    @(negedge clk);
    n = 1;
    check({tag, " R11 irq one cycle"}, irq, 0);
    if (irq == 0) begin
      int m;
      waitFor(1, 1, 50000, m);
      n += m;
    end
    check({tag, " R5 match interval"}, n, (cmp + 1) * scale);
    stopTimer();
  endtask

  task automatic testReset();
    check("R1 tmrOut after reset", tmrOut, 0);
    check("R1 irq after reset", irq, 0);
  endtask

  task automatic testBuffer();
    int n;
    @(negedge clk);
    extSrc = 1'b0; clkSel = 3'd0; cmpVal = 16'd5; runEn = 1'b1;
    @(negedge clk);
    @(negedge clk);
    cmpVal = 16'd1;
    waitFor(1, 1, 1000, n);
    check("R7 first match uses captured value", n + 2, 7);
    @(negedge clk);
    waitFor(1, 1, 1000, n);
    check("R7 interval uses captured value", n + 1, 6);
    stopTimer();
  endtask

  task automatic testDisable();
    int n;
    int seen = 0;
    @(negedge clk);
    extSrc = 1'b0; clkSel = 3'd0; cmpVal = 16'd3; runEn = 1'b1;
    repeat (2) @(negedge clk);
    runEn = 1'b0;
    @(negedge clk);
    check("R8 tmrOut cleared on stop", tmrOut, 0);
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (irq || tmrOut) seen++;
    end
    check("R8 quiet while stopped", seen, 0);
    runEn = 1'b1;
    waitFor(0, 1, 100, n);
    check("R8 restart first toggle", n, 1);
    waitFor(1, 1, 100, n);
    check("R8 restart first match", n + 1, 5);
    stopTimer();
  endtask

  task automatic testMode();
    int seen = 0;
    @(negedge clk);
    extSrc = 1'b0; clkSel = 3'd0; cmpVal = 16'd0; modeSel = 3'b001; runEn = 1'b1;
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (irq || tmrOut) seen++;
    end
    check("R9 non-interval mode inactive", seen, 0);
    runEn = 1'b0;
    modeSel = 3'b000;
    repeat (3) @(negedge clk);
  endtask

  int irqRises = 0;
  logic irqPrev = 1'b0;
  always @(negedge clk) begin
    if (irq && !irqPrev) irqRises++;
    irqPrev = irq;
  end

  task automatic pulseEvt();
    @(negedge clk); evtIn = 1'b1;
    repeat (2) @(negedge clk); evtIn = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic testExternal();
    int base;
    int seen = 0;
    @(negedge clk);
    extSrc = 1'b1; clkSel = 3'd0; cmpVal = 16'd2; runEn = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      if (tmrOut || irq) seen++;
    end
    check("R10 prescaler ignored in event mode", seen, 0);
    base = irqRises;
    pulseEvt();
    check("R10 R3 start on first event", tmrOut, 1);
    pulseEvt();
    pulseEvt();
    check("R10 no match before N+2 events", irqRises - base, 0);
    pulseEvt();
    check("R10 match on event N+2", irqRises - base, 1);
    check("R10 toggle on match", tmrOut, 0);
    pulseEvt(); pulseEvt(); pulseEvt();
    check("R10 R5 second match after N+1 events", irqRises - base, 2);
    stopTimer();
    extSrc = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testReset();
    runInternal(0, 3, "div1");
    runInternal(3, 2, "div8");
    runInternal(1, 0, "div2 cmp0");
    runInternal(7, 1, "div128");
    testBuffer();
    testDisable();
    testMode();
    testExternal();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule